// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Full-Match Alarm

This peripheral keeps wall-clock time as packed BCD bytes for seconds, minutes, hours, day of month, month and a two-digit year (2000 to 2099), plus a free-running day-of-week counter. A slow tick input, nominally 32.768 kHz, feeds a prescaler that produces one calendar step every `PRESC_DIV` ticks. The calendar step ripples through every field according to month lengths and leap years. Software reaches the block over a byte-wide register bus with word-spaced offsets, and receives two level interrupts: one for the once-per-second event and one for the alarm.

The prescaler is run by a four-state machine. `PH_HALT` holds the count while the run bit of the control register is 0. `PH_COUNT` advances the prescaler on each tick. `PH_WARN` is the final tick period before an update, and BUSY is raised there. `PH_ROLL` is a single-cycle state that performs the calendar step.

The transitions are as follows:
- HALT to COUNT, or HALT to WARN, on run=1. The choice depends on whether the held count is already at its last value.
- COUNT to WARN when the next count is the last.
- WARN to ROLL on a tick.
- ROLL back to COUNT or to WARN.
- Any state other than HALT returns to HALT on run=0.

A six-field alarm is compared against the freshly stepped time. It fires only when all six fields match exactly.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time reads 00 s, 00 min, 00 h, day 01, month 01, year 00 and weekday 00. The control register reads 0x00, status reads 0x80, the interrupt register reads 0x00, and both interrupt outputs are low.
- R2: Time fields sit at offsets 0x00 (s), 0x04 (min), 0x08 (h), 0x0C (day), 0x10 (month), 0x14 (year) and 0x18 (weekday). Alarm fields sit at 0x20 to 0x34 in the same order. A write loads the byte directly and a read returns it.
- R3: Any offset other than the mapped ones (0x00 to 0x18, 0x20 to 0x34, 0x40, 0x44, 0x48) reads 0x00, and a write to it changes no register.
- R4: Control bit 0 is the run bit. While it is 0, ticks change nothing. While it is 1, the time advances by one second every `PRESC_DIV` ticks. Status bit 1 reads 1 while counting is enabled.
- R5: Seconds and minutes wrap 59 to 00 and hours wrap 23 to 00. On an hour wrap the day advances and the weekday goes up by one, wrapping 06 to 00. After the last day of a month the day becomes 01 and the month advances. Month 12 wraps to 01 with a year increment, and year 99 wraps to 00.
- R6: February has 29 days when the two-digit year is divisible by 4 and 28 days otherwise. April, June, September and November have 30 days.
- R7: Status bit 0 (BUSY) reads 1 exactly during the last tick period before each update, and reads 0 again after the update.
- R8: Status bits 5, 4, 3 and 2 are the day, hour, minute and second events. They are set by the matching step, cleared by a read of status, and left unchanged by any write.
- R9: Status bit 6 is set at the step whose new time equals the alarm in all six fields. A difference in any single field prevents it from being set.
- R10: Status bits 7 (power-up, set by reset) and 6 (alarm) clear only when 1 is written to that position. Writing 0 leaves them as they are.
- R11: In the interrupt register at 0x48, bit 3 enables the alarm interrupt and bit 2 enables the periodic interrupt. The other bits read 0. `irq_alarm` is high while bit 3 and the alarm flag are both 1. `irq_tick` is high while bit 2 and the second event are both 1. Writing 0x00 drops both outputs.
- R12: Control bits 7 to 1 are stored and read back, and have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle enable per slow-oscillator period |
| bus_addr | input | 7 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a status read clears the event flags) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from `bus_addr`) |
| irq_tick | output | 1 | Periodic interrupt level |
| irq_alarm | output | 1 | Alarm interrupt level |

## Verification
A wrong prescaler phase shows up at the ports in two ways. The BUSY bit is seen one tick too early or too late, and the seconds field moves after the wrong number of ticks; both are caught on the first step checked. A wrong carry or month-length decision appears only when a field actually wraps. For that reason, directed year-end, leap-year and 30-day-month steps are mixed with random times biased toward 59 seconds and the last day of the month, so that a bad carry shows in the time registers within one step. A corrupted flag appears as a wrong status byte or interrupt level on the next read after the step.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int ADDR_W  = 7;
    localparam int FIELD_W = 8;
    localparam int NFIELD  = 6;   // s, min, h, day, month, year
    localparam int STAMP_W = FIELD_W * NFIELD;

    localparam logic [ADDR_W-1:0] A_WEEK = 7'h18;
    localparam logic [ADDR_W-1:0] A_CTRL = 7'h40;
    localparam logic [ADDR_W-1:0] A_STAT = 7'h44;
    localparam logic [ADDR_W-1:0] A_IEN  = 7'h48;

    // Field i lives in bits [8*i +: 8]; index 0 is seconds.
    typedef logic [STAMP_W-1:0] stamp_t;

    localparam stamp_t RESET_STAMP = 48'h00_01_01_00_00_00;

    typedef enum logic [1:0] {
        PH_HALT  = 2'd0,
        PH_COUNT = 2'd1,
        PH_WARN  = 2'd2,
        PH_ROLL  = 2'd3
    } phase_e;

    function automatic logic [7:0] bcd_up(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // 10*tens + ones is congruent to 2*tens + ones modulo 4
    function automatic logic leap_bcd(input logic [7:0] yr);
        logic [1:0] r;
        r = {yr[4], 1'b0} + yr[1:0];
        return (r == 2'd0);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mo, input logic [7:0] yr);
        logic [7:0] d;
        case (mo)
            8'h02:                      d = leap_bcd(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
            default:                    d = 8'h31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rtc_step_fsm.sv
module rtc_step_fsm import rtc_cal_pkg::*; #(
    parameter int unsigned DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run_req,
    output logic busy,
    output logic step,
    output logic running
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    phase_e phase, phase_nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    always_comb begin
        cnt_nxt = cnt;
        if (tick) cnt_nxt = (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_HALT: begin
                if (run_req) phase_nxt = (cnt == LAST) ? PH_WARN : PH_COUNT;
            end
            PH_COUNT, PH_ROLL: begin
                if (!run_req)              phase_nxt = PH_HALT;
                else if (cnt_nxt == LAST)  phase_nxt = PH_WARN;
                else                       phase_nxt = PH_COUNT;
            end
            PH_WARN: begin
                if (!run_req)  phase_nxt = PH_HALT;
                else if (tick) phase_nxt = PH_ROLL;
            end
            default: phase_nxt = PH_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_HALT;
            cnt   <= '0;
        end else begin
            phase <= phase_nxt;
            if (phase != PH_HALT && run_req) cnt <= cnt_nxt;
        end
    end

    always_comb begin
        busy    = 1'b0;
        step    = 1'b0;
        running = 1'b1;
        unique case (phase)
            PH_HALT:  running = 1'b0;
            PH_COUNT: ;
            PH_WARN:  busy = 1'b1;
            PH_ROLL:  step = 1'b1;
            default:  running = 1'b0;
        endcase
    end

endmodule

// File: rtl/rtc_cal_step.sv
module rtc_cal_step import rtc_cal_pkg::*; (
    input  stamp_t     cur,
    input  logic [7:0] wk,
    output stamp_t     nxt,
    output logic [7:0] wk_nxt,
    output logic       ev_min,
    output logic       ev_hour,
    output logic       ev_day
);
    logic [7:0]    lim  [NFIELD];
    logic [7:0]    base [NFIELD];
    logic [NFIELD:0] carry;

    always_comb begin
        lim[0]  = 8'h59;  base[0] = 8'h00;
        lim[1]  = 8'h59;  base[1] = 8'h00;
        lim[2]  = 8'h23;  base[2] = 8'h00;
        lim[3]  = month_last(cur[4*FIELD_W +: FIELD_W], cur[5*FIELD_W +: FIELD_W]);
        base[3] = 8'h01;
        lim[4]  = 8'h12;  base[4] = 8'h01;
        lim[5]  = 8'h99;  base[5] = 8'h00;
    end

    assign carry[0] = 1'b1;

    for (genvar i = 0; i < NFIELD; i++) begin : g_field
        logic [7:0] f;
        logic       wrap;
        assign f            = cur[i*FIELD_W +: FIELD_W];
        assign wrap         = (f >= lim[i]);
        assign carry[i+1]   = carry[i] & wrap;
        assign nxt[i*FIELD_W +: FIELD_W] = !carry[i] ? f : (wrap ? base[i] : bcd_up(f));
    end

    assign ev_min  = carry[1];
    assign ev_hour = carry[2];
    assign ev_day  = carry[3];
    assign wk_nxt  = !carry[3] ? wk : ((wk >= 8'h06) ? 8'h00 : bcd_up(wk));

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp import rtc_cal_pkg::*; (
    input  stamp_t now,
    input  stamp_t target,
    output logic   hit
);
    logic [NFIELD-1:0] eq;

    for (genvar i = 0; i < NFIELD; i++) begin : g_eq
        assign eq[i] = (now[i*FIELD_W +: FIELD_W] == target[i*FIELD_W +: FIELD_W]);
    end

    assign hit = &eq;

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar import rtc_cal_pkg::*; #(
    parameter int unsigned PRESC_DIV = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq_tick,
    output logic              irq_alarm
);
    stamp_t     now_q, alm_q, step_nxt;
    logic [7:0] wk_q, wk_nxt, ctrl_q;
    logic [1:0] ien_q;          // [1] alarm enable (bit3), [0] periodic enable (bit2)
    logic       pu_q, al_q;
    logic [3:0] ev_q;           // {day, hour, min, sec}
    logic       busy, step, running;
    logic       ev_min, ev_hour, ev_day, alm_hit;

    logic       is_time, is_alm, st_rd, st_wr;
    logic [2:0] fsel;
    logic [5:0] fbit;

    always_comb begin
        fsel    = bus_addr[4:2];
        fbit    = {fsel, 3'b000};
        is_time = (bus_addr[6:5] == 2'b00) && (bus_addr[1:0] == 2'b00) && (fsel < 3'd6);
        is_alm  = (bus_addr[6:5] == 2'b01) && (bus_addr[1:0] == 2'b00) && (fsel < 3'd6);
        st_rd   = bus_rd && (bus_addr == A_STAT);
        st_wr   = bus_wr && (bus_addr == A_STAT);
    end

    rtc_step_fsm #(.DIV(PRESC_DIV)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_32k),
        .run_req (ctrl_q[0]),
        .busy    (busy),
        .step    (step),
        .running (running)
    );

    rtc_cal_step u_step (
        .cur     (now_q),
        .wk      (wk_q),
        .nxt     (step_nxt),
        .wk_nxt  (wk_nxt),
        .ev_min  (ev_min),
        .ev_hour (ev_hour),
        .ev_day  (ev_day)
    );

    rtc_alarm_cmp u_cmp (
        .now    (step_nxt),
        .target (alm_q),
        .hit    (alm_hit)
    );

    // time and weekday: a bus write to a field wins over the step for that field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q <= RESET_STAMP;
            wk_q  <= 8'h00;
        end else begin
            if (step) begin
                now_q <= step_nxt;
                wk_q  <= wk_nxt;
            end
            if (bus_wr && is_time)           now_q[fbit +: FIELD_W] <= bus_wdata;
            if (bus_wr && bus_addr == A_WEEK) wk_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_q  <= '0;
            ctrl_q <= 8'h00;
            ien_q  <= 2'b00;
        end else if (bus_wr) begin
            if (is_alm)               alm_q[fbit +: FIELD_W] <= bus_wdata;
            if (bus_addr == A_CTRL)   ctrl_q <= bus_wdata;
            if (bus_addr == A_IEN)    ien_q  <= bus_wdata[3:2];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pu_q <= 1'b1;
            al_q <= 1'b0;
            ev_q <= 4'b0000;
        end else begin
            if (st_wr && bus_wdata[7]) pu_q <= 1'b0;

            if (step && alm_hit)            al_q <= 1'b1;
            else if (st_wr && bus_wdata[6]) al_q <= 1'b0;

            if (step)       ev_q <= {ev_day, ev_hour, ev_min, 1'b1} | (st_rd ? 4'b0000 : ev_q);
            else if (st_rd) ev_q <= 4'b0000;
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (is_time)
            bus_rdata = now_q[fbit +: FIELD_W];
        else if (is_alm)
            bus_rdata = alm_q[fbit +: FIELD_W];
        else begin
            case (bus_addr)
                A_WEEK:  bus_rdata = wk_q;
                A_CTRL:  bus_rdata = ctrl_q;
                A_STAT:  bus_rdata = {pu_q, al_q, ev_q, running, busy};
                A_IEN:   bus_rdata = {4'b0000, ien_q, 2'b00};
                default: bus_rdata = 8'h00;
            endcase
        end
    end

    assign irq_tick  = ien_q[0] & ev_q[0];
    assign irq_alarm = ien_q[1] & al_q;

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk import rtc_cal_pkg::*; (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic              irq_tick,
    input logic              irq_alarm,
    input logic              busy,
    input logic              running,
    input logic              step,
    input logic              pu_flag,
    input logic              al_flag,
    input logic [7:0]        sec
);
    // R7
    step_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> $past(busy));

    // R10
    pu_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pu_flag) |-> $past(bus_wr && bus_addr == A_STAT && bus_wdata[7]));

    // R9
    alarm_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(al_flag) |-> $past(step));

    // R8
    tick_irq_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_STAT && !step) |=> !irq_tick);

    // R11
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_IEN && bus_wdata == 8'h00) |=> (!irq_tick && !irq_alarm));

    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !bus_wr) |=> $stable(sec));

endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .irq_tick  (irq_tick),
    .irq_alarm (irq_alarm),
    .busy      (busy),
    .running   (running),
    .step      (step),
    .pu_flag   (pu_q),
    .al_flag   (al_q),
    .sec       (now_q[7:0])
);

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 8;

    typedef struct {
        int s; int m; int h; int d; int mo; int y; int w;
    } tm_t;

    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_tick, irq_alarm;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_calendar #(.PRESC_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick), .bus_addr(addr), .bus_wr(wr),
        .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq_tick(irq_tick), .irq_alarm(irq_alarm)
    );

    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;
    tm_t  m_t, m_alm;
    logic [3:0] m_ev = 4'b0;
    logic m_pu = 1'b1, m_al = 1'b0, m_run = 1'b0;

    function automatic logic [7:0] bcd(int v);
        return 8'(((v / 10) % 10) * 16 + (v % 10));
    endfunction

    function automatic int dim(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic tm_t inc(tm_t t);
        t.s++;
        if (t.s == 60) begin
            t.s = 0; t.m++;
            if (t.m == 60) begin
                t.m = 0; t.h++;
                if (t.h == 24) begin
                    t.h = 0; t.w = (t.w + 1) % 7; t.d++;
                    if (t.d > dim(t.mo, t.y)) begin
                        t.d = 1; t.mo++;
                        if (t.mo == 13) begin t.mo = 1; t.y = (t.y + 1) % 100; end
                    end
                end
            end
        end
        return t;
    endfunction

    function automatic bit same6(tm_t a, tm_t b);
        return a.s == b.s && a.m == b.m && a.h == b.h && a.d == b.d && a.mo == b.mo && a.y == b.y;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(logic [6:0] a, logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(logic [6:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic ticks(int n);
        repeat (n) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic advance(int secs);
        ticks(secs * DIV);
        repeat (secs) begin
            m_t = inc(m_t);
            m_ev[0] = 1'b1;
            if (m_t.s == 0) m_ev[1] = 1'b1;
            if (m_t.s == 0 && m_t.m == 0) m_ev[2] = 1'b1;
            if (m_t.s == 0 && m_t.m == 0 && m_t.h == 0) m_ev[3] = 1'b1;
            if (same6(m_t, m_alm)) m_al = 1'b1;
        end
    endtask

    task automatic load_time(tm_t t);
        wr_reg(7'h00, bcd(t.s));  wr_reg(7'h04, bcd(t.m));  wr_reg(7'h08, bcd(t.h));
        wr_reg(7'h0C, bcd(t.d));  wr_reg(7'h10, bcd(t.mo)); wr_reg(7'h14, bcd(t.y));
        wr_reg(7'h18, bcd(t.w));
        m_t = t;
    endtask

    task automatic load_alarm(tm_t t);
        wr_reg(7'h20, bcd(t.s));  wr_reg(7'h24, bcd(t.m));  wr_reg(7'h28, bcd(t.h));
        wr_reg(7'h2C, bcd(t.d));  wr_reg(7'h30, bcd(t.mo)); wr_reg(7'h34, bcd(t.y));
        m_alm = t;
    endtask

    task automatic check_time(string tag);
        logic [7:0] v;
        rd_reg(7'h00, v); check({tag, " sec"},  v, bcd(m_t.s));
        rd_reg(7'h04, v); check({tag, " min"},  v, bcd(m_t.m));
        rd_reg(7'h08, v); check({tag, " hour"}, v, bcd(m_t.h));
        rd_reg(7'h0C, v); check({tag, " day"},  v, bcd(m_t.d));
        rd_reg(7'h10, v); check({tag, " mon"},  v, bcd(m_t.mo));
        rd_reg(7'h14, v); check({tag, " year"}, v, bcd(m_t.y));
        rd_reg(7'h18, v); check({tag, " week"}, v, bcd(m_t.w));
    endtask

    task automatic check_status(string tag, logic busy_exp);
        logic [7:0] v;
        rd_reg(7'h44, v);
        check({tag, " status"}, v, {m_pu, m_al, m_ev, m_run, busy_exp});
        m_ev = 4'b0;
    endtask

    function automatic tm_t mk(int y, int mo, int d, int h, int m, int s, int w);
        tm_t t;
        t.y = y; t.mo = mo; t.d = d; t.h = h; t.m = m; t.s = s; t.w = w;
        return t;
    endfunction

    function automatic tm_t rand_tm();
        tm_t t;
        t.y  = $urandom_range(0, 99);
        t.mo = $urandom_range(1, 12);
        t.d  = ($urandom_range(0, 2) == 0) ? dim(t.mo, t.y) : $urandom_range(1, dim(t.mo, t.y));
        t.h  = ($urandom_range(0, 2) == 0) ? 23 : $urandom_range(0, 23);
        t.m  = ($urandom_range(0, 2) == 0) ? 59 : $urandom_range(0, 59);
        t.s  = ($urandom_range(0, 1) == 0) ? 59 : $urandom_range(0, 59);
        t.w  = $urandom_range(0, 6);
        return t;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        tm_t t;
        void'($urandom(32'd20240229));
        m_t   = mk(0, 1, 1, 0, 0, 0, 0);
        m_alm = mk(0, 0, 0, 0, 0, 0, 0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_time("R1");
        rd_reg(7'h40, v); check("R1 ctrl", v, 8'h00);
        rd_reg(7'h48, v); check("R1 ien", v, 8'h00);
        check_status("R1", 1'b0);
        check("R1 irq_tick", {7'b0, irq_tick}, 8'h00);
        check("R1 irq_alarm", {7'b0, irq_alarm}, 8'h00);

        // R10 write-one-to-clear power-up
        wr_reg(7'h44, 8'h00);  check_status("R10 write0", 1'b0);
        wr_reg(7'h44, 8'h80);  m_pu = 1'b0; check_status("R10 write1", 1'b0);

        // R3 reserved offsets
        wr_reg(7'h1C, 8'hFF); wr_reg(7'h38, 8'hFF); wr_reg(7'h4C, 8'hFF); wr_reg(7'h01, 8'h33);
        rd_reg(7'h1C, v); check("R3 0x1C", v, 8'h00);
        rd_reg(7'h38, v); check("R3 0x38", v, 8'h00);
        rd_reg(7'h4C, v); check("R3 0x4C", v, 8'h00);
        rd_reg(7'h01, v); check("R3 0x01", v, 8'h00);
        check_time("R3 untouched");

        // R12 / R4: control bits stored, stopped clock ignores ticks
        wr_reg(7'h40, 8'hA4);
        rd_reg(7'h40, v); check("R12 ctrl readback", v, 8'hA4);
        ticks(3 * DIV);
        check_time("R4 stopped");
        check_status("R4 stopped", 1'b0);
        wr_reg(7'h40, 8'hFF); m_run = 1'b1;
        rd_reg(7'h40, v); check("R12 ctrl all ones", v, 8'hFF);
        advance(2);
        check_time("R12 no effect");
        wr_reg(7'h40, 8'h01);

        // R11 interrupt register bits
        wr_reg(7'h48, 8'hFF); rd_reg(7'h48, v); check("R11 ien mask", v, 8'h0C);
        wr_reg(7'h48, 8'h00); rd_reg(7'h48, v); check("R11 ien zero", v, 8'h00);

        // R2 load and read back, alarm registers
        load_time(mk(37, 7, 14, 9, 26, 53, 3));
        check_time("R2 load");
        load_alarm(mk(45, 11, 30, 22, 15, 8, 0));
        rd_reg(7'h20, v); check("R2 alarm sec", v, 8'h08);
        rd_reg(7'h2C, v); check("R2 alarm day", v, 8'h30);
        rd_reg(7'h34, v); check("R2 alarm year", v, 8'h45);
        check_status("R2 clear", 1'b0);

        // R7 busy on last tick period
        ticks(DIV - 1);
        check_status("R7 busy set", 1'b1);
        check_time("R7 not yet stepped");
        advance(0); ticks(1);
        m_t = inc(m_t); m_ev[0] = 1'b1;
        check_status("R7 busy clear", 1'b0);
        check_time("R7 stepped");

        // R5 year-end rollover with all events
        load_time(mk(99, 12, 31, 23, 59, 59, 6));
        advance(1);
        check_time("R5 year end");
        check_status("R5 events", 1'b0);
        // R6 leap and short months
        load_time(mk(24, 2, 28, 23, 59, 59, 1)); advance(1); check_time("R6 leap 28");
        load_time(mk(24, 2, 29, 23, 59, 59, 2)); advance(1); check_time("R6 leap 29");
        load_time(mk(23, 2, 28, 23, 59, 59, 2)); advance(1); check_time("R6 common 28");
        load_time(mk(31, 4, 30, 23, 59, 59, 5)); advance(1); check_time("R6 april 30");
        check_status("R6 events", 1'b0);

        // R8 / R11 periodic interrupt
        wr_reg(7'h48, 8'h04);
        advance(1);
        check("R11 irq_tick high", {7'b0, irq_tick}, 8'h01);
        wr_reg(7'h44, 8'h3C);
        check("R8 write keeps event", {7'b0, irq_tick}, 8'h01);
        check_status("R8 read", 1'b0);
        check("R8 irq_tick cleared", {7'b0, irq_tick}, 8'h00);

        // R9 alarm full match
        wr_reg(7'h48, 8'h08);
        t = inc(inc(inc(m_t)));
        load_alarm(t);
        advance(3);
        check("R9 irq_alarm", {7'b0, irq_alarm}, 8'h01);
        check_status("R9 alarm flag", 1'b0);
        wr_reg(7'h44, 8'h00);
        check("R10 alarm kept", {7'b0, irq_alarm}, 8'h01);
        wr_reg(7'h44, 8'h40); m_al = 1'b0;
        check("R10 alarm cleared", {7'b0, irq_alarm}, 8'h00);
        t = inc(inc(m_t)); t.y = (t.y + 1) % 100;
        load_alarm(t);
        advance(2);
        check("R9 one field differs", {7'b0, irq_alarm}, 8'h00);
        check_status("R9 no flag", 1'b0);
        wr_reg(7'h48, 8'h00);
        check("R11 both off", {6'b0, irq_alarm, irq_tick}, 8'h00);

        // random times, biased toward wraps
        for (int k = 0; k < 30; k++) begin
            int n;
            load_time(rand_tm());
            n = ($urandom_range(0, 4) == 0) ? 61 : $urandom_range(1, 4);
            advance(n);
            check_time("R5 random");
            check_status("R8 random", 1'b0);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule